// File: doc/BRIEF.md
# Calendar Timekeeping Core with Freeze-and-Commit Set

This block turns a 32.768 kHz clock enable into a one-second tick and keeps a binary calendar of second, minute, hour, day of month, month and two-digit year (00 to 99 for the years 2000 to 2099). It runs on the system clock. The slow timebase arrives as a one-cycle enable pulse, so no second clock domain is needed. The live calendar and the tick leave the block on dedicated outputs, where alarm and event-capture logic compare against them. Time zone and daylight-saving policy are left to software.

A host sets the time in a fixed order. It raises freeze, writes fields one at a time through a select/data port, drops freeze and reads the result back. While freeze is high the sub-second divider is held at zero and no second is counted. The first tick therefore comes one full second after release. Every write is range-checked against the calendar state at that moment. A value that would leave the calendar inconsistent is refused and raises a sticky error flag. To read the time, the host pulses a snapshot strobe that copies all six fields at once into a held shadow set. A read can therefore never mix fields from two different seconds.

Top module: `rtc_calendar_core`

## Requirements
- R1: One `sec_tick` pulse, one cycle wide, is produced for every PRESC_DIV cycles in which `tick32k_en` is high while `freeze` is low. It appears in the cycle after the edge that samples the enable completing the count.
- R2: On the edge after a `sec_tick`, seconds advance. Second 59 wraps to 0 and carries into minutes, minute 59 wraps to 0 and carries into hours, and hour 23 wraps to 0 and carries into the day.
- R3: After the last day of a month, the day returns to 1 and the month advances. Months 4, 6, 9 and 11 have 30 days; months 1, 3, 5, 7, 8, 10 and 12 have 31.
- R4: February has 29 days when the year field is a multiple of 4 (this includes 0, meaning 2000) and 28 days otherwise.
- R5: After 23:59:59 on December 31, the calendar moves to January 1 of the next year, and year 99 wraps to 0.
- R6: While `freeze` is high, the divider is held at zero, no tick is produced and any pending tick is dropped. After `freeze` falls, the first tick needs exactly PRESC_DIV further enables.
- R7: Field writes take effect only on an edge where both `wr_en` and `freeze` are high. The select codes are 0 second, 1 minute, 2 hour, 3 day, 4 month and 5 year. A write with `freeze` low changes nothing and sets no flag.
- R8: A frozen write is refused in these cases: second or minute above 59; hour above 23; day equal to 0 or beyond the current month's length; month outside 1..12, or a month shorter than the current day; year above 99, or a year that makes the current February day illegal; select 6 or 7. A refused write leaves every field unchanged and sets `wr_invalid`. `inval_clr` clears `wr_invalid`, but a refusal on the same edge wins.
- R9: A `snap` pulse copies all six live fields, as they stood before that edge, into the `shd_*` outputs. These outputs then hold until the next `snap`.
- R10: Reset sets the live and shadow calendars to year 0, month 1, day 1, 00:00:00. It also clears the divider, `sec_tick` and `wr_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick32k_en | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| freeze | input | 1 | Holds counting and opens the field write port |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select (0 sec .. 5 year) |
| wr_data | input | 7 | Binary value to write |
| snap | input | 1 | Copies live fields into the shadow set |
| inval_clr | input | 1 | Clears the invalid-write flag |
| sec_tick | output | 1 | One-second pulse |
| now_sec | output | 6 | Live second |
| now_min | output | 6 | Live minute |
| now_hour | output | 5 | Live hour |
| now_day | output | 5 | Live day of month |
| now_mon | output | 4 | Live month |
| now_year | output | 7 | Live year, 0..99 |
| shd_sec | output | 6 | Shadow second |
| shd_min | output | 6 | Shadow minute |
| shd_hour | output | 5 | Shadow hour |
| shd_day | output | 5 | Shadow day |
| shd_mon | output | 4 | Shadow month |
| shd_year | output | 7 | Shadow year |
| wr_invalid | output | 1 | Sticky flag for refused writes |

## Verification
The bench sets times just before the month, year and leap-day boundaries. A design with a wrong month-length table or leap rule lands on a day that does not exist, and one with a broken carry advances the wrong field. It counts enables from the falling edge of freeze: a divider that is not cleared on freeze fires its first tick early, and one that queues ticks jumps forward after release. Illegal writes, including month and year changes that would strand the current day, must leave the calendar untouched and raise the flag. Accepting them would leave a calendar that later rolls over from an impossible date. Shadow outputs are checked to stay fixed across several live ticks; a shadow that tracks the live fields would fail this.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int SEC_W  = 6;
   localparam int MIN_W  = 6;
   localparam int HOUR_W = 5;
   localparam int DAY_W  = 5;
   localparam int MON_W  = 4;
   localparam int YEAR_W = 7;
   localparam int WD_W   = 7;
   localparam int SEL_W  = 3;

   localparam int SEC_LAST  = 59;
   localparam int MIN_LAST  = 59;
   localparam int HOUR_LAST = 23;
   localparam int MON_LAST  = 12;
   localparam int YEAR_LAST = 99;

   localparam logic [SEL_W-1:0] SEL_SEC  = 3'd0;
   localparam logic [SEL_W-1:0] SEL_MIN  = 3'd1;
   localparam logic [SEL_W-1:0] SEL_HOUR = 3'd2;
   localparam logic [SEL_W-1:0] SEL_DAY  = 3'd3;
   localparam logic [SEL_W-1:0] SEL_MON  = 3'd4;
   localparam logic [SEL_W-1:0] SEL_YEAR = 3'd5;

   typedef struct packed {
      logic [YEAR_W-1:0] year;
      logic [MON_W-1:0]  month;
      logic [DAY_W-1:0]  day;
      logic [HOUR_W-1:0] hour;
      logic [MIN_W-1:0]  minute;
      logic [SEC_W-1:0]  sec;
   } cal_t;

   localparam int CAL_W = $bits(cal_t);

   localparam cal_t CAL_RESET = '{year: 7'd0, month: 4'd1, day: 5'd1,
                                  hour: 5'd0, minute: 6'd0, sec: 6'd0};

   // Two-digit year inside 2000..2099: every multiple of four is leap.
   function automatic logic is_leap(input logic [YEAR_W-1:0] y);
      return (y[1:0] == 2'b00);
   endfunction

   function automatic logic [DAY_W-1:0] month_len(input logic [MON_W-1:0]  m,
                                                  input logic [YEAR_W-1:0] y);
      case (m)
         4'd2:                   return is_leap(y) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic hold,
   output logic tick
);
   localparam int  CW       = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  IS_POW2  = ((DIV & (DIV - 1)) == 0);

   logic [CW-1:0] cnt;
   logic          at_end;

   generate
      if (IS_POW2) begin : g_pow2
         // Full-width counter: the last count is all ones, wrap is free.
         assign at_end = &cnt;
      end else begin : g_cmp
         assign at_end = (cnt == CW'(DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else begin
         tick <= en && !hold && at_end;
         if (hold)
            cnt <= '0;
         else if (en)
            cnt <= at_end ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rtc_field_guard.sv
module rtc_field_guard
   import rtc_cal_pkg::*;
(
   input  cal_t             cur,
   input  logic [SEL_W-1:0] sel,
   input  logic [WD_W-1:0]  data,
   output logic             ok
);
   logic [DAY_W-1:0] len_now;
   logic [DAY_W-1:0] len_new_mon;
   logic [DAY_W-1:0] len_new_year;

   assign len_now      = month_len(cur.month, cur.year);
   assign len_new_mon  = month_len(data[MON_W-1:0], cur.year);
   assign len_new_year = month_len(cur.month, data[YEAR_W-1:0]);

   always_comb begin
      case (sel)
         SEL_SEC:  ok = (data <= WD_W'(SEC_LAST));
         SEL_MIN:  ok = (data <= WD_W'(MIN_LAST));
         SEL_HOUR: ok = (data <= WD_W'(HOUR_LAST));
         SEL_DAY:  ok = (data != '0) && (data <= WD_W'(len_now));
         SEL_MON:  ok = (data != '0) && (data <= WD_W'(MON_LAST))
                        && (cur.day <= len_new_mon);
         SEL_YEAR: ok = (data <= WD_W'(YEAR_LAST))
                        && (cur.day <= len_new_year);
         default:  ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
   import rtc_cal_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             wr_go,
   input  logic             wr_ok,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [WD_W-1:0]  wr_data,
   output cal_t             cal
);
   cal_t             nxt;
   logic [DAY_W-1:0] cur_len;
   logic             wrap_s, wrap_m, wrap_h, wrap_d, wrap_mo;

   assign cur_len = month_len(cal.month, cal.year);

   // Carry chain: each stage wraps only if every lower stage wraps.
   assign wrap_s  = (cal.sec    == SEC_W'(SEC_LAST));
   assign wrap_m  = wrap_s && (cal.minute == MIN_W'(MIN_LAST));
   assign wrap_h  = wrap_m && (cal.hour   == HOUR_W'(HOUR_LAST));
   assign wrap_d  = wrap_h && (cal.day    == cur_len);
   assign wrap_mo = wrap_d && (cal.month  == MON_W'(MON_LAST));

   always_comb begin
      nxt = cal;
      if (adv) begin
         nxt.sec = wrap_s ? '0 : cal.sec + 1'b1;
         if (wrap_s)  nxt.minute = wrap_m ? '0 : cal.minute + 1'b1;
         if (wrap_m)  nxt.hour   = wrap_h ? '0 : cal.hour + 1'b1;
         if (wrap_h)  nxt.day    = wrap_d ? DAY_W'(1) : cal.day + 1'b1;
         if (wrap_d)  nxt.month  = wrap_mo ? MON_W'(1) : cal.month + 1'b1;
         if (wrap_mo) nxt.year   = (cal.year == YEAR_W'(YEAR_LAST)) ? '0
                                                                 : cal.year + 1'b1;
      end else if (wr_go && wr_ok) begin
         case (wr_sel)
            SEL_SEC:  nxt.sec    = wr_data[SEC_W-1:0];
            SEL_MIN:  nxt.minute = wr_data[MIN_W-1:0];
            SEL_HOUR: nxt.hour   = wr_data[HOUR_W-1:0];
            SEL_DAY:  nxt.day    = wr_data[DAY_W-1:0];
            SEL_MON:  nxt.month  = wr_data[MON_W-1:0];
            SEL_YEAR: nxt.year   = wr_data[YEAR_W-1:0];
            default:  nxt = cal;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cal <= CAL_RESET;
      else        cal <= nxt;
   end

endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot #(
   parameter int           W    = 8,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= INIT;
      else if (load) q <= d;
   end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int PRESC_DIV = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick32k_en,
   input  logic              freeze,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [WD_W-1:0]   wr_data,
   input  logic              snap,
   input  logic              inval_clr,
   output logic              sec_tick,
   output logic [SEC_W-1:0]  now_sec,
   output logic [MIN_W-1:0]  now_min,
   output logic [HOUR_W-1:0] now_hour,
   output logic [DAY_W-1:0]  now_day,
   output logic [MON_W-1:0]  now_mon,
   output logic [YEAR_W-1:0] now_year,
   output logic [SEC_W-1:0]  shd_sec,
   output logic [MIN_W-1:0]  shd_min,
   output logic [HOUR_W-1:0] shd_hour,
   output logic [DAY_W-1:0]  shd_day,
   output logic [MON_W-1:0]  shd_mon,
   output logic [YEAR_W-1:0] shd_year,
   output logic              wr_invalid
);

   generate
      if (PRESC_DIV < 2) begin : g_bad_div
         $error("rtc_calendar_core: PRESC_DIV must be at least 2");
      end
      if (WD_W < YEAR_W) begin : g_bad_wd
         $error("rtc_calendar_core: write data narrower than year field");
      end
   endgenerate

   cal_t cal;
   cal_t shadow;
   logic adv;
   logic wr_go;
   logic wr_ok;

   rtc_prescaler #(.DIV(PRESC_DIV)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (tick32k_en),
      .hold (freeze),
      .tick (sec_tick)
   );

   // A tick that meets a freeze is dropped rather than deferred.
   assign adv   = sec_tick && !freeze;
   assign wr_go = wr_en && freeze;

   rtc_field_guard u_guard (
      .cur (cal),
      .sel (wr_sel),
      .data(wr_data),
      .ok  (wr_ok)
   );

   rtc_cal_counter u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .wr_go  (wr_go),
      .wr_ok  (wr_ok),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .cal    (cal)
   );

   rtc_snapshot #(.W(CAL_W), .INIT(CAL_RESET)) u_shadow (
      .clk  (clk),
      .rst_n(rst_n),
      .load (snap),
      .d    (cal),
      .q    (shadow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                wr_invalid <= 1'b0;
      else if (wr_go && !wr_ok)  wr_invalid <= 1'b1;
      else if (inval_clr)        wr_invalid <= 1'b0;
   end

   assign now_sec  = cal.sec;
   assign now_min  = cal.minute;
   assign now_hour = cal.hour;
   assign now_day  = cal.day;
   assign now_mon  = cal.month;
   assign now_year = cal.year;

   assign shd_sec  = shadow.sec;
   assign shd_min  = shadow.minute;
   assign shd_hour = shadow.hour;
   assign shd_day  = shadow.day;
   assign shd_mon  = shadow.month;
   assign shd_year = shadow.year;

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       freeze,
   input logic       wr_en,
   input logic       snap,
   input logic       inval_clr,
   input logic       sec_tick,
   input logic [5:0] now_sec,
   input logic [5:0] now_min,
   input logic [4:0] now_hour,
   input logic [4:0] now_day,
   input logic [3:0] now_mon,
   input logic [6:0] now_year,
   input logic [5:0] shd_sec,
   input logic [5:0] shd_min,
   input logic [4:0] shd_hour,
   input logic [4:0] shd_day,
   input logic [3:0] shd_mon,
   input logic [6:0] shd_year,
   input logic       wr_invalid
);
   logic [32:0] now_all;
   logic [32:0] shd_all;

   assign now_all = {now_year, now_mon, now_day, now_hour, now_min, now_sec};
   assign shd_all = {shd_year, shd_mon, shd_day, shd_hour, shd_min, shd_sec};

   a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   a_r6_frozen_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> !sec_tick);

   a_r6_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !wr_en) |=> $stable(now_all));

   a_r7_live_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && !sec_tick) |=> $stable(now_all));

   a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(shd_all));

   a_r9_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
      snap |=> (shd_all == $past(now_all)));

   a_r8_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_invalid && !inval_clr) |=> wr_invalid);

   always @(posedge clk) begin
      if (rst_n) begin
         a_r2_field_range: assert (now_sec <= 6'd59 && now_min <= 6'd59
                                   && now_hour <= 5'd23);
         a_r3_date_range: assert (now_day >= 5'd1 && now_day <= 5'd31
                                  && now_mon >= 4'd1 && now_mon <= 4'd12
                                  && now_year <= 7'd99);
      end
   end

endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .freeze    (freeze),
   .wr_en     (wr_en),
   .snap      (snap),
   .inval_clr (inval_clr),
   .sec_tick  (sec_tick),
   .now_sec   (now_sec),
   .now_min   (now_min),
   .now_hour  (now_hour),
   .now_day   (now_day),
   .now_mon   (now_mon),
   .now_year  (now_year),
   .shd_sec   (shd_sec),
   .shd_min   (shd_min),
   .shd_hour  (shd_hour),
   .shd_day   (shd_day),
   .shd_mon   (shd_mon),
   .shd_year  (shd_year),
   .wr_invalid(wr_invalid)
);

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
   localparam int DIV = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick32k_en = 1'b0;
   logic       freeze = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = '0;
   logic [6:0] wr_data = '0;
   logic       snap = 1'b0;
   logic       inval_clr = 1'b0;
   logic       sec_tick;
   logic [5:0] now_sec, now_min, shd_sec, shd_min;
   logic [4:0] now_hour, now_day, shd_hour, shd_day;
   logic [3:0] now_mon, shd_mon;
   logic [6:0] now_year, shd_year;
   logic       wr_invalid;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 0;
   string cur_req  = "R10";

   // Bench model: index 0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year.
   int m[6];
   int ms[6];
   bit m_tq;
   int m_pc;
   bit m_inv;

   always #2.5 clk = ~clk;

   rtc_calendar_core #(.PRESC_DIV(DIV)) i_rtc_calendar_core (
      .clk(clk), .rst_n(rst_n), .tick32k_en(tick32k_en), .freeze(freeze),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .snap(snap),
      .inval_clr(inval_clr), .sec_tick(sec_tick),
      .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
      .now_day(now_day), .now_mon(now_mon), .now_year(now_year),
      .shd_sec(shd_sec), .shd_min(shd_min), .shd_hour(shd_hour),
      .shd_day(shd_day), .shd_mon(shd_mon), .shd_year(shd_year),
      .wr_invalid(wr_invalid)
   );

   function automatic int mlen(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic bit legal(int sel, int d);
      case (sel)
         0, 1:    return d <= 59;
         2:       return d <= 23;
         3:       return d >= 1 && d <= mlen(m[4], m[5]);
         4:       return d >= 1 && d <= 12 && m[3] <= mlen(d, m[5]);
         5:       return d <= 99 && m[3] <= mlen(m[4], d);
         default: return 0;
      endcase
   endfunction

   function automatic longint pk(int y, int mo, int d, int h, int mi, int s);
      return ((((longint'(y) * 16 + mo) * 32 + d) * 32 + h) * 64 + mi) * 64 + s;
   endfunction

   function automatic longint dut_now();
      return pk(now_year, now_mon, now_day, now_hour, now_min, now_sec);
   endfunction

   function automatic longint dut_shd();
      return pk(shd_year, shd_mon, shd_day, shd_hour, shd_min, shd_sec);
   endfunction

   task automatic chk(string req, string what, longint act, longint exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_advance();
      m[0]++;
      if (m[0] == 60) begin
         m[0] = 0; m[1]++;
         if (m[1] == 60) begin
            m[1] = 0; m[2]++;
            if (m[2] == 24) begin
               m[2] = 0; m[3]++;
               if (m[3] > mlen(m[4], m[5])) begin
                  m[3] = 1; m[4]++;
                  if (m[4] == 13) begin
                     m[4] = 1; m[5] = (m[5] + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   // One clock: update the model from the inputs seen at the edge, then compare.
   task automatic step();
      bit lg;
      bit ntq;
      @(posedge clk);
      if (snap) ms = m;
      lg = legal(int'(wr_sel), int'(wr_data));
      if (m_tq && !freeze) model_advance();
      else if (freeze && wr_en && lg) m[wr_sel] = int'(wr_data);
      if (freeze && wr_en && !lg) m_inv = 1;
      else if (inval_clr) m_inv = 0;
      ntq = !freeze && tick32k_en && (m_pc == DIV - 1);
      if (freeze) m_pc = 0;
      else if (tick32k_en) m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
      m_tq = ntq;
      @(negedge clk);
      chk(cur_req, "sec_tick", longint'(sec_tick), longint'(m_tq));
      chk(cur_req, "live", dut_now(), pk(m[5], m[4], m[3], m[2], m[1], m[0]));
      chk(cur_req, "shadow", dut_shd(), pk(ms[5], ms[4], ms[3], ms[2], ms[1], ms[0]));
      chk(cur_req, "wr_invalid", longint'(wr_invalid), longint'(m_inv));
   endtask

   task automatic wr(int sel, int d);
      wr_en = 1; wr_sel = 3'(sel); wr_data = 7'(d);
      step();
      wr_en = 0;
   endtask

   task automatic do_snap();
      snap = 1; step(); snap = 0;
   endtask

   task automatic set_time(int y, int mo, int d, int h, int mi, int s);
      freeze = 1; tick32k_en = 0;
      step();
      wr(3, 1); wr(5, y); wr(4, mo); wr(3, d); wr(2, h); wr(1, mi); wr(0, s);
      freeze = 0;
   endtask

   task automatic run_to_tick(output int n);
      tick32k_en = 1; n = 0;
      for (int i = 0; i < 100; i++) begin
         step(); n++;
         if (sec_tick) break;
      end
      step();
      tick32k_en = 0;
   endtask

   task automatic roll(string req, int y, int mo, int d, int h, int mi, int s,
                       int ey, int emo, int ed, int eh, int emi, int es);
      int n;
      cur_req = req;
      set_time(y, mo, d, h, mi, s);
      run_to_tick(n);
      chk(req, "rolled time", dut_now(), pk(ey, emo, ed, eh, emi, es));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      longint held;
      void'($urandom(32'd20240607));
      m = '{0, 0, 0, 1, 1, 0};
      ms = m; m_tq = 0; m_pc = 0; m_inv = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R10: reset state before any edge after release
      chk("R10", "reset live", dut_now(), pk(0, 1, 1, 0, 0, 0));
      chk("R10", "reset shadow", dut_shd(), pk(0, 1, 1, 0, 0, 0));
      chk("R10", "reset tick", longint'(sec_tick), 0);
      chk("R10", "reset invalid", longint'(wr_invalid), 0);
      step();

      // R7: write with freeze low has no effect and no flag
      cur_req = "R7";
      wr(0, 30);
      do_snap();
      chk("R7", "unfrozen write ignored", dut_shd(), pk(0, 1, 1, 0, 0, 0));
      chk("R7", "unfrozen write no flag", longint'(wr_invalid), 0);

      // R5 and R6: year end and 99 wrap; first tick exactly DIV enables after release
      cur_req = "R5";
      set_time(99, 12, 31, 23, 59, 59);
      run_to_tick(n);
      chk("R6", "enables to first tick", longint'(n), longint'(DIV));
      chk("R5", "year wrap", dut_now(), pk(0, 1, 1, 0, 0, 0));
      roll("R5", 7, 12, 31, 23, 59, 59, 8, 1, 1, 0, 0, 0);

      // R3 and R4: month ends and leap rules
      roll("R4", 1, 2, 28, 23, 59, 59, 1, 3, 1, 0, 0, 0);
      roll("R4", 4, 2, 28, 23, 59, 59, 4, 2, 29, 0, 0, 0);
      roll("R4", 4, 2, 29, 23, 59, 59, 4, 3, 1, 0, 0, 0);
      roll("R4", 0, 2, 28, 23, 59, 59, 0, 2, 29, 0, 0, 0);
      roll("R3", 5, 4, 30, 23, 59, 59, 5, 5, 1, 0, 0, 0);
      roll("R3", 5, 1, 31, 23, 59, 59, 5, 2, 1, 0, 0, 0);
      roll("R3", 5, 8, 30, 23, 59, 59, 5, 8, 31, 0, 0, 0);
      // R2: carries
      roll("R2", 5, 6, 15, 23, 59, 59, 5, 6, 16, 0, 0, 0);
      roll("R2", 5, 6, 15, 10, 59, 59, 5, 6, 15, 11, 0, 0);
      roll("R2", 5, 6, 15, 10, 20, 30, 5, 6, 15, 10, 20, 31);
      // R1: tick period over several seconds with continuous enable
      cur_req = "R1";
      tick32k_en = 1;
      repeat (5 * DIV) step();
      tick32k_en = 0;
      chk("R1", "five seconds", dut_now(), pk(5, 6, 15, 10, 20, 36));

      // R8: refused writes keep fields and set the sticky flag
      cur_req = "R8";
      set_time(5, 4, 30, 12, 0, 0);
      freeze = 1;
      wr(0, 60);
      chk("R8", "sec 60 flag", longint'(wr_invalid), 1);
      wr(2, 24); wr(4, 13); wr(4, 0); wr(3, 0); wr(3, 31); wr(4, 2); wr(7, 1); wr(5, 100);
      do_snap();
      chk("R8", "fields kept", dut_shd(), pk(5, 4, 30, 12, 0, 0));
      wr(0, 45);
      chk("R8", "flag sticky after good write", longint'(wr_invalid), 1);
      chk("R8", "good write applied", longint'(now_sec), 45);
      inval_clr = 1; step(); inval_clr = 0;
      chk("R8", "flag cleared", longint'(wr_invalid), 0);
      wr(3, 1); wr(4, 2); wr(5, 4); wr(3, 29);
      wr(5, 5);
      chk("R8", "year making Feb 29 illegal", longint'(now_year), 4);
      inval_clr = 1; wr(6, 0); inval_clr = 0;
      chk("R8", "refusal beats clear", longint'(wr_invalid), 1);
      inval_clr = 1; step(); inval_clr = 0;
      wr(5, 8);
      chk("R8", "leap to leap year accepted", longint'(now_year), 8);
      chk("R8", "no flag on legal year", longint'(wr_invalid), 0);

      // R6: ticks while frozen are dropped
      cur_req = "R6";
      set_time(10, 3, 3, 3, 3, 3);
      freeze = 1; tick32k_en = 1;
      repeat (6 * DIV) step();
      chk("R6", "frozen no advance", dut_now(), pk(10, 3, 3, 3, 3, 3));
      freeze = 0;
      run_to_tick(n);
      chk("R6", "first tick after long freeze", longint'(n), longint'(DIV));
      chk("R6", "single second after release", dut_now(), pk(10, 3, 3, 3, 3, 4));

      // R9: shadow holds across live ticks
      cur_req = "R9";
      do_snap();
      held = dut_shd();
      tick32k_en = 1;
      repeat (4 * DIV) step();
      tick32k_en = 0;
      chk("R9", "shadow held", dut_shd(), held);
      do_snap();
      chk("R9", "shadow refreshed", dut_shd(), dut_now());

      // Random phase across a leap-day boundary
      cur_req = "R2";
      set_time(4, 2, 28, 23, 59, 50);
      for (int i = 0; i < 3000; i++) begin
         tick32k_en = $urandom_range(0, 1);
         if ($urandom_range(0, 39) == 0) freeze = ~freeze;
         wr_en = freeze && ($urandom_range(0, 3) == 0);
         wr_sel = 3'($urandom_range(0, 7));
         wr_data = 7'($urandom_range(0, 70));
         snap = ($urandom_range(0, 7) == 0);
         inval_clr = ($urandom_range(0, 15) == 0);
         step();
      end
      wr_en = 0; snap = 0; inval_clr = 0; freeze = 0; tick32k_en = 0;
      step();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule